// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic core of a small 8-bit controller, together with its status register. Each cycle in which `op_valid` is high, it combines an accumulator operand with a second operand, taken from data memory or from an immediate, under a 4-bit operation code. It registers the 8-bit result and updates the carry, auxiliary carry, zero and overflow flags. The result and the new flags appear together on the next cycle.

The same status register holds two system flags: a power-down flag and a watchdog time-out flag. Neither an operation nor a software write to the register can change them. They respond only to four single-cycle event inputs: power-up, clear-watchdog, halt and watchdog timeout. Instruction decode and skip branching stay outside the block. An external decoder drives the operation code and the events.

Top module: `alu8_status`

## Requirements
- R1: The status output has C at bit 0, AC at bit 1, Z at bit 2, OV at bit 3, PDF at bit 4 and TO at bit 5, and bits 7:6 always read 0. While `rst_n` is low, the result, `res_valid` and every status bit are cleared.
- R2: Codes ADD (0) and ADC (1) give A+B and A+B+C. C is set when the sum carries out of bit 7, and AC is set when the low nibble carries into bit 4.
- R3: Codes SUB (2) and SBC (3) give A-B and A-B-(1-C). C is set when no borrow occurs, and AC is set when the low nibble needs no borrow.
- R4: Every operation that updates Z sets it exactly when its 8-bit result is zero.
- R5: For ADD, ADC, SUB and SBC, OV is set when the carry into bit 7 differs from the carry out of bit 7.
- R6: AND (5), OR (6), XOR (7), CPL (8, gives ~A), INC (13) and DEC (14) update Z only, and leave C, AC and OV unchanged.
- R7: RL (9) and RR (10) rotate the 8 bits of A and change no flag. RLC (11) and RRC (12) rotate through C as a ninth bit, change C only, and take the bit shifted out into C.
- R8: DAA (4) adds 06h to A if A's low nibble exceeds 9 or AC is set. It then adds 60h if the high part of that sum exceeds 9 or C is set, and in that case sets C. DAA changes C only.
- R9: A status write (`st_wr_en`) loads bits 3:0 of `st_wr_data` into C, AC, Z and OV and never changes PDF or TO. When a write and an operation fall in the same cycle, the write sets the flags.
- R10: PDF is cleared by power-up or clear-watchdog. Otherwise it is set by halt, and without an event it holds.
- R11: TO is cleared by power-up, clear-watchdog or halt. Otherwise it is set by watchdog timeout, and without an event it holds.
- R12: The result and flags of an operation appear the cycle after `op_valid`, with `res_valid` high. Code PASS (15) returns A and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform the operation this cycle |
| op_code | input | 4 | Operation code |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Memory or immediate operand |
| st_wr_en | input | 1 | Software write to the status register |
| st_wr_data | input | 8 | Status write data (bits 3:0 used) |
| ev_powerup | input | 1 | Power-up event |
| ev_clrwdt | input | 1 | Clear-watchdog event |
| ev_halt | input | 1 | Halt event |
| ev_wdt_to | input | 1 | Watchdog timeout event |
| res_o | output | 8 | Registered result |
| res_valid | output | 1 | Result from the previous cycle's operation |
| status_o | output | 8 | Status register |

## Verification
Additions use operand pairs chosen so that nibble carry, full carry, signed overflow and a zero result each occur on their own, which isolates each flag. Subtractions use larger-minus-smaller, smaller-minus-larger, equal operands and the most-negative boundary, with C both set and clear, to separate the borrow sense from the carry-in. Decimal adjust follows additions that leave only the low fix, only the high fix, or both. Logic, rotate and increment operations run with C, AC and OV preset to opposite values, so that any flag they must not touch would show up. The status-register event inputs are also driven in combination, which confirms that clearing wins over setting and that software writes cannot reach PDF or TO.

// File: rtl/alu8_pkg.sv
// Shared types for the ALU: operation codes and the per-operation flag update.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_DAA  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RR   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RRC  = 4'd12,
        OP_INC  = 4'd13,
        OP_DEC  = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    // Which arithmetic flags an operation writes, and their new values.
    typedef struct packed {
        logic c_en;
        logic ac_en;
        logic z_en;
        logic ov_en;
        logic c;
        logic ac;
        logic z;
        logic ov;
    } flag_upd_t;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor split into a low half, a middle slice and the top bit,
// so that the half carry, the carry into the MSB and the carry out are all
// available without recomputation. Subtraction is A + ~B + cin, so the
// carry out means "no borrow". Assumes DW is even and at least 4.
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          ac_out,
    output logic          ov_out
);
    localparam int HALF = DW / 2;
    localparam int MW   = DW - 1 - HALF;

    logic [DW-1:0] b_eff;
    logic [HALF:0] lo;
    logic [MW:0]   mid;
    logic [1:0]    top;

    // Three-stage ripple of the sum with the intermediate carries kept.
    always_comb begin
        b_eff  = sub ? ~b : b;
        lo     = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
        mid    = {1'b0, a[DW-2:HALF]} + {1'b0, b_eff[DW-2:HALF]} + {{MW{1'b0}}, lo[HALF]};
        top    = {1'b0, a[DW-1]} + {1'b0, b_eff[DW-1]} + {1'b0, mid[MW]};
        sum    = {top[0], mid[MW-1:0], lo[HALF-1:0]};
        c_out  = top[1];
        ac_out = lo[HALF];
        ov_out = top[1] ^ mid[MW];
    end

endmodule

// File: rtl/alu8_daa.sv
// Decimal adjust of the accumulator after a BCD addition. Assumes an
// 8-bit datapath holding two BCD digits.
module alu8_daa (
    input  logic [7:0] a,
    input  logic       ac,
    input  logic       c,
    output logic [7:0] r,
    output logic       c_out
);
    logic       lo_fix;
    logic       hi_fix;
    logic [8:0] t;

    // Low-digit correction first, then the high digit sees its carry.
    always_comb begin
        lo_fix = (a[3:0] > 4'd9) || ac;
        t      = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
        hi_fix = (t[7:4] > 4'd9) || c || t[8];
        r      = t[7:0] + (hi_fix ? 8'h60 : 8'h00);
        c_out  = hi_fix;
    end

endmodule

// File: rtl/alu8_misc.sv
// Logic, complement, rotate, increment, decrement and pass-through
// operations. Only the rotates through carry produce a new carry.
module alu8_misc
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c,
    output logic [DW-1:0] r,
    output logic          c_out
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    // Result mux for the non-adder operations.
    always_comb begin
        r     = a;
        c_out = c;
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_CPL:  r = ~a;
            OP_RL:   r = {a[DW-2:0], a[DW-1]};
            OP_RR:   r = {a[0], a[DW-1:1]};
            OP_RLC:  begin r = {a[DW-2:0], c}; c_out = a[DW-1]; end
            OP_RRC:  begin r = {c, a[DW-1:1]}; c_out = a[0];    end
            OP_INC:  r = a + ONE;
            OP_DEC:  r = a - ONE;
            default: r = a;
        endcase
    end

endmodule

// File: rtl/alu8_status_reg.sv
// Status register. The arithmetic flags follow operations or software
// writes, and a write wins. PDF and TO respond only to the event inputs,
// and clearing events win over setting ones.
module alu8_status_reg
    import alu8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_fire,
    input  flag_upd_t upd,
    input  logic      sw_wr,
    input  logic [3:0] sw_data,
    input  logic      ev_powerup,
    input  logic      ev_clrwdt,
    input  logic      ev_halt,
    input  logic      ev_wdt_to,
    output logic [7:0] status
);
    logic c_q, ac_q, z_q, ov_q, pdf_q, to_q;

    // Arithmetic flags: software write, else selective update by operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            ac_q <= 1'b0;
            z_q  <= 1'b0;
            ov_q <= 1'b0;
        end else if (sw_wr) begin
            c_q  <= sw_data[0];
            ac_q <= sw_data[1];
            z_q  <= sw_data[2];
            ov_q <= sw_data[3];
        end else if (op_fire) begin
            if (upd.c_en)  c_q  <= upd.c;
            if (upd.ac_en) ac_q <= upd.ac;
            if (upd.z_en)  z_q  <= upd.z;
            if (upd.ov_en) ov_q <= upd.ov;
        end
    end

    // System flags: driven by events only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdf_q <= 1'b0;
            to_q  <= 1'b0;
        end else begin
            if (ev_powerup || ev_clrwdt)         pdf_q <= 1'b0;
            else if (ev_halt)                    pdf_q <= 1'b1;
            if (ev_powerup || ev_clrwdt || ev_halt) to_q <= 1'b0;
            else if (ev_wdt_to)                  to_q  <= 1'b1;
        end
    end

    assign status = {2'b00, to_q, pdf_q, ov_q, z_q, ac_q, c_q};

    // R10
    pdf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_powerup && !ev_clrwdt && !ev_halt) |=> $stable(status[4]));
    // R10
    halt_pdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_halt && !ev_powerup && !ev_clrwdt) |=> status[4]);
    // R11
    to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_powerup && !ev_clrwdt && !ev_halt && !ev_wdt_to) |=> $stable(status[5]));
    // R11
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_powerup || ev_clrwdt || ev_halt) |=> !status[5]);
    // R9
    swwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> status[3:0] == $past(sw_data));

endmodule

// File: rtl/alu8_status.sv
// Top: routes operands to the adder, decimal-adjust and misc units, picks
// the result and flag update for the opcode, and registers the result.
// Assumes the decoder supplies one operation per cycle at most.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          st_wr_en,
    input  logic [7:0]    st_wr_data,
    input  logic          ev_powerup,
    input  logic          ev_clrwdt,
    input  logic          ev_halt,
    input  logic          ev_wdt_to,
    output logic [DW-1:0] res_o,
    output logic          res_valid,
    output logic [7:0]    status_o
);
    alu_op_e       op;
    logic          c_cur, ac_cur;
    logic          is_sub, as_cin;
    logic [DW-1:0] as_sum, daa_r, misc_r, res_d;
    logic          as_c, as_ac, as_ov, daa_c, misc_c;
    flag_upd_t     upd;
    logic [DW-1:0] res_q;
    logic          vld_q;

    assign op     = alu_op_e'(op_code);
    assign c_cur  = status_o[0];
    assign ac_cur = status_o[1];

    // Subtract select and carry-in for the adder.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC);
        unique case (op)
            OP_ADC, OP_SBC: as_cin = c_cur;
            OP_SUB:         as_cin = 1'b1;
            default:        as_cin = 1'b0;
        endcase
    end

    alu8_addsub #(.DW(DW)) addsub_i (
        .a(opnd_a), .b(opnd_b), .sub(is_sub), .cin(as_cin),
        .sum(as_sum), .c_out(as_c), .ac_out(as_ac), .ov_out(as_ov)
    );

    alu8_daa daa_i (
        .a(opnd_a[7:0]), .ac(ac_cur), .c(c_cur), .r(daa_r), .c_out(daa_c)
    );

    alu8_misc #(.DW(DW)) misc_i (
        .op(op), .a(opnd_a), .b(opnd_b), .c(c_cur), .r(misc_r), .c_out(misc_c)
    );

    // Result select and flag-update class per opcode.
    always_comb begin
        upd = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_d     = as_sum;
                upd.c_en  = 1'b1; upd.c  = as_c;
                upd.ac_en = 1'b1; upd.ac = as_ac;
                upd.ov_en = 1'b1; upd.ov = as_ov;
                upd.z_en  = 1'b1;
            end
            OP_DAA: begin
                res_d    = daa_r;
                upd.c_en = 1'b1; upd.c = daa_c;
            end
            OP_RLC, OP_RRC: begin
                res_d    = misc_r;
                upd.c_en = 1'b1; upd.c = misc_c;
            end
            OP_RL, OP_RR, OP_PASS: res_d = misc_r;
            default: begin
                res_d    = misc_r;
                upd.z_en = 1'b1;
            end
        endcase
        upd.z = (res_d == '0);
    end

    // Result register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) res_q <= res_d;
        end
    end

    alu8_status_reg st_i (
        .clk(clk), .rst_n(rst_n), .op_fire(op_valid), .upd(upd),
        .sw_wr(st_wr_en), .sw_data(st_wr_data[3:0]),
        .ev_powerup(ev_powerup), .ev_clrwdt(ev_clrwdt),
        .ev_halt(ev_halt), .ev_wdt_to(ev_wdt_to), .status(status_o)
    );

    assign res_o     = res_q;
    assign res_valid = vld_q;

    // R4
    z_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !st_wr_en && (op == OP_AND || op == OP_OR || op == OP_XOR ||
         op == OP_ADD || op == OP_SUB || op == OP_INC || op == OP_DEC))
        |=> status_o[2] == (res_o == '0));
    // R6
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !st_wr_en && (op == OP_AND || op == OP_OR || op == OP_XOR ||
         op == OP_CPL || op == OP_INC || op == OP_DEC))
        |=> ($stable(status_o[1:0]) && $stable(status_o[3])));
    // R12
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !st_wr_en && op == OP_PASS)
        |=> (res_valid && res_o == $past(opnd_a) && $stable(status_o[3:0])));
    // R7
    rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !st_wr_en && (op == OP_RL || op == OP_RR))
        |=> $stable(status_o[3:0]));

endmodule

// File: tb/alu8_status_tb_top.sv
module alu8_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic       st_wr_en = 1'b0;
    logic [7:0] st_wr_data = '0;
    logic       ev_powerup = 1'b0, ev_clrwdt = 1'b0, ev_halt = 1'b0, ev_wdt_to = 1'b0;
    logic [7:0] res_o, status_o;
    logic       res_valid;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // model state
    bit m_c, m_ac, m_z, m_ov, m_pdf, m_to;
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    alu8_status dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data), .ev_powerup(ev_powerup), .ev_clrwdt(ev_clrwdt),
        .ev_halt(ev_halt), .ev_wdt_to(ev_wdt_to), .res_o(res_o),
        .res_valid(res_valid), .status_o(status_o)
    );

    function automatic logic [7:0] m_stat();
        return {2'b00, m_to, m_pdf, m_ov, m_z, m_ac, m_c};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: compute expectation from the requirements, push, drive.
    task automatic issue(input string tag, input int op, input int a, input int b,
                         input bit wr = 0, input int wd = 0);
        int r, s, cin, ta, tb2;
        r = a;
        case (op)
            0, 1: begin
                cin = (op == 1) ? int'(m_c) : 0;
                s = a + b + cin; r = s & 255;
                m_c = (s > 255); m_ac = (((a & 15) + (b & 15) + cin) > 15);
                m_ov = (a[7] == b[7]) && (r[7] != a[7]); m_z = (r == 0);
            end
            2, 3: begin
                cin = (op == 3) ? int'(m_c) : 1;
                s = a - b - (1 - cin); r = s & 255;
                m_c = (a >= b + (1 - cin)); m_ac = ((a & 15) >= (b & 15) + (1 - cin));
                m_ov = (a[7] != b[7]) && (r[7] != a[7]); m_z = (r == 0);
            end
            4: begin
                s = a;
                if ((a & 15) > 9 || m_ac) s = s + 6;
                if ((s >> 4) > 9 || m_c) begin s = s + 'h60; m_c = 1; end
                r = s & 255;
            end
            5: begin r = a & b; m_z = (r == 0); end
            6: begin r = a | b; m_z = (r == 0); end
            7: begin r = a ^ b; m_z = (r == 0); end
            8: begin r = (~a) & 255; m_z = (r == 0); end
            9: r = ((a << 1) | (a >> 7)) & 255;
            10: r = ((a >> 1) | (a << 7)) & 255;
            11: begin ta = a >> 7; r = ((a << 1) | int'(m_c)) & 255; m_c = ta[0]; end
            12: begin tb2 = a & 1; r = (a >> 1) | (int'(m_c) << 7); m_c = tb2[0]; end
            13: begin r = (a + 1) & 255; m_z = (r == 0); end
            14: begin r = (a - 1) & 255; m_z = (r == 0); end
            default: r = a;
        endcase
        if (wr) begin
            m_c = wd[0]; m_ac = wd[1]; m_z = wd[2]; m_ov = wd[3];
        end
        @(negedge clk);
        q_exp.push_back({r[7:0], m_stat()});
        q_tag.push_back(tag);
        op_valid = 1'b1; op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        st_wr_en = wr; st_wr_data = wd[7:0];
    endtask

    task automatic idle(input int n = 2);
        @(negedge clk);
        op_valid = 1'b0; st_wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic event_pulse(input string tag, input bit pw, input bit cl,
                               input bit ht, input bit wd);
        @(negedge clk);
        ev_powerup = pw; ev_clrwdt = cl; ev_halt = ht; ev_wdt_to = wd;
        if (pw || cl) m_pdf = 0; else if (ht) m_pdf = 1;
        if (pw || cl || ht) m_to = 0; else if (wd) m_to = 1;
        @(negedge clk);
        ev_powerup = 0; ev_clrwdt = 0; ev_halt = 0; ev_wdt_to = 0;
        chk(tag, {8'h00, status_o}, {8'h00, m_stat()});
    endtask

    task automatic sw_write(input string tag, input int d);
        @(negedge clk);
        st_wr_en = 1; st_wr_data = d[7:0];
        m_c = d[0]; m_ac = d[1]; m_z = d[2]; m_ov = d[3];
        @(negedge clk);
        st_wr_en = 0;
        chk(tag, {8'h00, status_o}, {8'h00, m_stat()});
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_exp.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R12: unexpected result %h expected none", res_o);
            end else begin
                automatic logic [15:0] e = q_exp.pop_front();
                automatic string t = q_tag.pop_front();
                chk(t, {res_o, status_o}, e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {res_o, status_o}, 16'h0000);
        chk("R1 reset valid", {15'd0, res_valid}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 additions, R4 zero, R5 overflow
        issue("R2 add nibble carry", 0, 'h3A, 'h2C);
        issue("R2 R4 add wrap zero", 0, 'hFF, 'h01);
        issue("R2 adc with carry", 1, 'h10, 'h20);
        issue("R5 add overflow", 0, 'h7F, 'h01);
        issue("R5 add neg overflow", 0, 'h80, 'h80);
        // R3 subtraction
        issue("R3 sub no borrow", 2, 'h50, 'h21);
        issue("R3 sub borrow", 2, 'h20, 'h50);
        issue("R3 sbc borrow in", 3, 'h40, 'h10);
        issue("R3 R4 sub equal", 2, 'h33, 'h33);
        issue("R5 sub overflow", 2, 'h80, 'h01);
        issue("R3 sbc carry set", 3, 'h0F, 'h01);
        idle();

        // R8 decimal adjust
        issue("R8 add bcd", 0, 'h19, 'h28);
        issue("R8 daa low fix", 4, 'h41, 0);
        issue("R8 add bcd hi", 0, 'h99, 'h01);
        issue("R8 daa both", 4, 'h9A, 0);
        issue("R8 add plain", 0, 'h12, 'h13);
        issue("R8 daa none", 4, 'h25, 0);
        issue("R8 daa high only", 4, 'hA3, 0);
        idle();

        // R6 logic with flags preset opposite
        sw_write("R9 preset", 'h0B);
        issue("R6 and zero", 5, 'hF0, 'h0F);
        issue("R6 or", 6, 'h00, 'h81);
        issue("R6 xor zero", 7, 'h5A, 'h5A);
        issue("R6 cpl", 8, 'hFF, 0);
        issue("R6 R4 inc wrap", 13, 'hFF, 0);
        issue("R6 dec zero", 14, 'h01, 0);
        issue("R6 dec wrap", 14, 'h00, 0);
        idle();

        // R7 rotates
        sw_write("R9 c clear", 'h00);
        issue("R7 rl", 9, 'h81, 0);
        issue("R7 rr", 10, 'h01, 0);
        issue("R7 rlc out1", 11, 'h80, 0);
        issue("R7 rlc in1", 11, 'h01, 0);
        issue("R7 rrc out1", 12, 'h01, 0);
        issue("R7 rrc in1", 12, 'h02, 0);
        issue("R12 pass", 15, 'hC3, 'h11);
        idle();

        // R9 write plus op in the same cycle
        issue("R9 write beats op", 0, 'hFF, 'h01, 1, 'hF5);
        idle();

        // R10 / R11 events
        event_pulse("R10 halt sets pdf", 0, 0, 1, 0);
        event_pulse("R11 wdt sets to", 0, 0, 0, 1);
        sw_write("R9 write ignores pdf to", 'h00);
        sw_write("R9 write high bits", 'hFF);
        event_pulse("R11 halt clears to", 0, 0, 1, 1);
        event_pulse("R11 wdt again", 0, 0, 0, 1);
        event_pulse("R10 R11 clrwdt", 0, 1, 1, 1);
        event_pulse("R10 halt", 0, 0, 1, 0);
        event_pulse("R10 R11 powerup", 1, 0, 0, 1);
        issue("R12 op after events", 2, 'h05, 'h03);
        idle(3);

        chk("R12 queue drained", 16'(q_exp.size()), 16'h0000);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule